// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A century flag shares the hours byte. A free-running prescaler divides the block clock (nominally 32.768 kHz) down to one advance per second. Each counter passes a carry to the next one when it wraps. The length of each month, including February in leap years, is selected from the current month and year with no software help.

A bus front end reaches the counters through a small register port with a 3-bit address. A write loads the addressed counter directly. A write to the seconds register also restarts the sub-second phase. Reads go through a shadow copy taken on a snapshot request. A front end asks for one snapshot at the start of a multi-byte read, and every byte it then reads comes from the same instant, even when a second boundary passes during the read.

Top module: `bcd_timekeeper`

## Requirements
- R1: After synchronous reset the counters hold seconds 00, minutes 00, hours 00, century 0, day of week 01, date 01, month 01 and year 00. Read data is 00 at every address until the first snapshot is taken.
- R2: With no write, the seconds counter advances by one BCD step once every 2^PRESC_BITS clock cycles. The first advance occurs on the 2^PRESC_BITS-th rising edge after reset is released.
- R3: Seconds and minutes count 00 to 59 and hours count 00 to 23. A wrap returns the counter to 00 and advances the next counter in the chain by one.
- R4: When the hours wrap, the day of week advances from 01 to 07 and then returns to 01.
- R5: When the hours wrap, the date advances. After 31 it returns to 01 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. A date wrap advances the month, a month wrap from 12 to 01 advances the year, and the year goes from 99 to 00.
- R6: February wraps after 29 when the BCD year is a multiple of four, and after 28 otherwise. A multiple of four is an even tens digit with a units digit of 0, 4 or 8, or an odd tens digit with a units digit of 2 or 6. Year 00 counts as a leap year.
- R7: The century flag is bit 7 of the hours byte. It toggles each time the year wraps from 99 to 00.
- R8: The register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write stores its data ANDed with a per-address mask, and the stored value is visible from the next cycle. The masks are 7F, 7F, BF, 07, 3F, 1F and FF; on address 2, bit 7 loads the century flag. A write to address 7 changes nothing.
- R9: A cycle that carries a write does not advance the prescaler, so no seconds advance is taken in that cycle. A write to address 0 clears the prescaler, so the next advance comes a full 2^PRESC_BITS cycles after that write.
- R10: A snapshot request in a cycle copies the counter values held before that clock edge into the read shadow. rd_data shows the shadow byte at reg_addr (00 at address 7). It does not change with later counter advances until the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, nominally 32.768 kHz |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wr_en | input | 1 | Load the addressed counter this cycle |
| reg_wr_data | input | 8 | Write data in packed BCD |
| snap_req | input | 1 | Copy all counters into the read shadow |
| rd_data | output | 8 | Shadow byte at reg_addr |

## Verification
A wrong carry or a wrong limit inside the chain stays hidden until a wrap reaches it. The bench therefore sets each counter one second short of its wrap points: end of minute, end of day, February in leap and common years, a 30-day month, and the end of a century. It then reads the whole shadow one boundary later, so a fault appears at the read port within one second of simulated time. A prescaler that drifts or fails to restart shows up as the seconds advance one snapshot early or late. A shadow that follows the live counters shows up when bytes are read after several ticks with no new snapshot.

// File: rtl/bcdtk_pkg.sv
// Package: shared constants and BCD helpers for the time-of-day counter.
// Assumes all stored values are packed BCD, one byte per field.
package bcdtk_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 7;
    localparam int NUM_REGS   = 8;
    localparam int ADDR_W     = $clog2(NUM_REGS);

    // Next BCD value with a decimal carry from the units into the tens digit.
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisibility by four of a two-digit BCD year, worked out on its digits.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last date of a BCD month.
    function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Lowest value of each field (day of week, date and month start at one).
    function automatic logic [7:0] field_floor(input int idx);
        return (idx >= 3 && idx <= 5) ? 8'h01 : 8'h00;
    endfunction

    // Bits a write may set in each field.
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2:       return 8'h3F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/bcdtk_prescaler.sv
// Prescaler: free-running binary divider that emits one tick each 2^BITS cycles.
// Assumes hold and clear come from the register port; either one suppresses the tick.
module bcdtk_prescaler #(
    parameter int BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clear,
    output logic tick
);
    localparam logic [BITS-1:0] LAST = '1;

    logic [BITS-1:0] count;

    // Tick on the last count of the period, unless a write owns this cycle.
    assign tick = !hold && !clear && (count == LAST);

    // Count cycles; restart on clear, stand still on hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (!hold)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/bcdtk_field.sv
// BCD field counter: one time or calendar field with a load and a runtime ceiling.
// Assumes step_en and load_en never occur together; the load wins if they do.
module bcdtk_field #(
    parameter logic [7:0] FLOOR = 8'h00,
    parameter logic [7:0] MASK  = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    input  logic [7:0] ceiling,
    input  logic       load_en,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic       wrap
);
    logic at_top;

    // At or above the ceiling: an out-of-range loaded value also wraps.
    assign at_top = (value >= ceiling);
    assign wrap   = step_en && at_top;

    // Load, wrap to the floor, or take one BCD step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= FLOOR;
        else if (load_en)
            value <= load_val & MASK;
        else if (step_en)
            value <= at_top ? FLOOR : bcdtk_pkg::bcd_next(value);
    end
endmodule

// File: rtl/bcdtk_snapshot.sv
// Read shadow: captures all register bytes at once and serves them by address.
// Assumes live bytes are stable before the capturing edge.
module bcdtk_snapshot #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           capture,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] live,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow;

    // Take a coherent copy of every byte on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (capture)
            shadow <= live;
    end

    // Select the requested byte.
    assign rd_data = shadow[rd_addr];
endmodule

// File: rtl/bcd_timekeeper.sv
// Top: BCD time-of-day and calendar counter chain with a register port.
// Assumes clk is the time base; 2^PRESC_BITS cycles make one second.
module bcd_timekeeper #(
    parameter int PRESC_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    input  logic       snap_req,
    output logic [7:0] rd_data
);
    import bcdtk_pkg::*;

    localparam int FIELD_SEC  = 0;
    localparam int FIELD_HOUR = 2;
    localparam int FIELD_YEAR = 6;

    logic                                 tick;
    logic                                 sec_load;
    logic                                 century;
    logic [NUM_FIELDS-1:0]                fstep;
    logic [NUM_FIELDS-1:0]                fload;
    logic [NUM_FIELDS-1:0]                fw;
    logic [NUM_FIELDS-1:0][DATA_W-1:0]    fv;
    logic [NUM_FIELDS-1:0][DATA_W-1:0]    fceil;
    logic [NUM_REGS-1:0][DATA_W-1:0]      live;

    assign sec_load = reg_wr_en && (reg_addr == ADDR_W'(FIELD_SEC));

    bcdtk_prescaler #(.BITS(PRESC_BITS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (reg_wr_en),
        .clear (sec_load),
        .tick  (tick)
    );

    // Carry chain: day of week and date both follow the hours wrap.
    always_comb begin
        fstep[0] = tick;
        fstep[1] = fw[0];
        fstep[2] = fw[1];
        fstep[3] = fw[2];
        fstep[4] = fw[2];
        fstep[5] = fw[4];
        fstep[6] = fw[5];
    end

    // Per-field ceilings; the date ceiling follows month and leap year.
    always_comb begin
        fceil[0] = 8'h59;
        fceil[1] = 8'h59;
        fceil[2] = 8'h23;
        fceil[3] = 8'h07;
        fceil[4] = month_len(fv[5], is_leap(fv[6]));
        fceil[5] = 8'h12;
        fceil[6] = 8'h99;
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign fload[i] = reg_wr_en && (reg_addr == ADDR_W'(i));
        bcdtk_field #(
            .FLOOR (field_floor(i)),
            .MASK  (field_mask(i))
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en  (fstep[i]),
            .ceiling  (fceil[i]),
            .load_en  (fload[i]),
            .load_val (reg_wr_data),
            .value    (fv[i]),
            .wrap     (fw[i])
        );
        assign live[i] = (i == FIELD_HOUR) ? (fv[i] | {century, 7'b0}) : fv[i];
    end
    assign live[NUM_REGS-1] = '0;

    // Century flag: loaded with the hours byte, flipped on a year wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            century <= 1'b0;
        else if (fload[FIELD_HOUR])
            century <= reg_wr_data[7];
        else if (fw[FIELD_YEAR])
            century <= !century;
    end

    bcdtk_snapshot #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (snap_req),
        .live    (live),
        .rd_addr (reg_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/bcdtk_checker.sv
// Checker: temporal properties of the counter chain, bound into the top.
// Assumes it sees the field values and wraps of bcd_timekeeper.
module bcdtk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       reg_wr_en,
    input logic [7:0] reg_wr_data,
    input logic       snap_req,
    input logic [7:0] rd_data,
    input logic       tick,
    input logic [7:0] sec_v,
    input logic [7:0] min_v,
    input logic [7:0] hour_v,
    input logic [7:0] dow_v,
    input logic [7:0] date_v,
    input logic [7:0] mon_v,
    input logic       century,
    input logic       hour_wrap,
    input logic       min_wrap,
    input logic       dow_wrap,
    input logic       date_wrap,
    input logic       year_wrap
);
    AST_RESET_VALUES: assert property (@(posedge clk) !rst_n |=> (dow_v == 8'h01 && date_v == 8'h01 && !century)); // R1
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (tick && sec_v == 8'h09) |=> sec_v == 8'h10); // R2
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && sec_v == 8'h59) |=> (sec_v == 8'h00 && min_v != $past(min_v))); // R3
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (min_wrap && hour_v == 8'h23) |=> hour_v == 8'h00); // R3
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n) dow_wrap |=> dow_v == 8'h01); // R4
    AST_APRIL_END: assert property (@(posedge clk) disable iff (!rst_n) (hour_wrap && mon_v == 8'h04 && date_v == 8'h30) |=> date_v == 8'h01); // R5
    AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (date_wrap && mon_v == 8'h12) |=> mon_v == 8'h01); // R5
    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n) year_wrap |=> century != $past(century)); // R7
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && reg_addr == 3'd0) |=> sec_v == ($past(reg_wr_data) & 8'h7F)); // R8
    AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_en |-> !tick); // R9
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(snap_req) && $stable(reg_addr)) |-> $stable(rd_data)); // R10
endmodule

bind bcd_timekeeper bcdtk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .snap_req    (snap_req),
    .rd_data     (rd_data),
    .tick        (tick),
    .sec_v       (fv[0]),
    .min_v       (fv[1]),
    .hour_v      (fv[2]),
    .dow_v       (fv[3]),
    .date_v      (fv[4]),
    .mon_v       (fv[5]),
    .century     (century),
    .min_wrap    (fw[1]),
    .hour_wrap   (fw[2]),
    .dow_wrap    (fw[3]),
    .date_wrap   (fw[4]),
    .year_wrap   (fw[6])
);

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
// Bench: directed wrap cases plus seeded random times, checked against a bench model.
module sim_bcd_timekeeper;
    localparam int PB     = 4;
    localparam int PERIOD = 1 << PB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic       snap_req = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_reg [8];
    logic [7:0] m_snap [8];
    int phase;

    bcd_timekeeper #(.PRESC_BITS(PB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .snap_req(snap_req), .rd_data(rd_data)
    );

    always #2 clk = !clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int days_of(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] wmask(input int a);
        case (a)
            0, 1: return 8'h7F;
            2:    return 8'hBF;
            3:    return 8'h07;
            4:    return 8'h3F;
            5:    return 8'h1F;
            6:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_reg = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
        m_snap = '{default: 8'h00};
        phase = 0;
    endtask

    // One second of model time, R2..R7.
    task automatic model_tick();
        int s, mi, h, dw, dt, mo, y;
        logic c;
        s = b2i(m_reg[0]); mi = b2i(m_reg[1]); h = b2i(m_reg[2] & 8'h3F);
        c = m_reg[2][7]; dw = b2i(m_reg[3]); dt = b2i(m_reg[4]);
        mo = b2i(m_reg[5]); y = b2i(m_reg[6]);
        if (s >= 59) begin
            s = 0;
            if (mi >= 59) begin
                mi = 0;
                if (h >= 23) begin
                    h = 0;
                    dw = (dw >= 7) ? 1 : dw + 1;
                    if (dt >= days_of(mo, y)) begin
                        dt = 1;
                        if (mo >= 12) begin
                            mo = 1;
                            if (y >= 99) begin y = 0; c = !c; end
                            else y = y + 1;
                        end else mo = mo + 1;
                    end else dt = dt + 1;
                end else h = h + 1;
            end else mi = mi + 1;
        end else s = s + 1;
        m_reg[0] = i2b(s); m_reg[1] = i2b(mi); m_reg[2] = i2b(h) | {c, 7'b0};
        m_reg[3] = i2b(dw); m_reg[4] = i2b(dt); m_reg[5] = i2b(mo); m_reg[6] = i2b(y);
    endtask

    // Model of one clock edge: snapshot, write (R8, R9) or prescaler advance.
    task automatic model_edge(input bit we, input logic [2:0] a, input logic [7:0] d, input bit sn);
        if (sn) m_snap = m_reg;
        if (we) begin
            if (a == 3'd0) phase = 0;
            if (a != 3'd7) m_reg[a] = d & wmask(int'(a));
        end else if (phase == PERIOD - 1) begin
            phase = 0;
            model_tick();
        end else begin
            phase = phase + 1;
        end
    endtask

    task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d, input bit sn);
        @(negedge clk);
        reg_wr_en = we; reg_addr = a; reg_wr_data = d; snap_req = sn;
        @(posedge clk);
        model_edge(we, a, d, sn);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic check_addr(input logic [2:0] a, input string tag);
        @(negedge clk);
        reg_wr_en = 1'b0; snap_req = 1'b0; reg_addr = a; reg_wr_data = 8'h00;
        #1;
        checks++;
        if (rd_data !== m_snap[a]) begin
            errors++;
            $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rd_data, m_snap[a]);
        end
        @(posedge clk);
        model_edge(1'b0, a, 8'h00, 1'b0);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) check_addr(3'(a), tag);
    endtask

    task automatic snap_read(input string tag);
        step(1'b0, 3'd0, 8'h00, 1'b1);
        read_all(tag);
    endtask

    // Seconds written last so the prescaler phase restarts with the new time.
    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] hc,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        step(1'b1, 3'd1, mi, 1'b0);
        step(1'b1, 3'd2, hc, 1'b0);
        step(1'b1, 3'd3, dw, 1'b0);
        step(1'b1, 3'd4, dt, 1'b0);
        step(1'b1, 3'd5, mo, 1'b0);
        step(1'b1, 3'd6, y, 1'b0);
        step(1'b1, 3'd0, s, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        model_edge(1'b0, 3'd0, 8'h00, 1'b0);

        // R1: shadow empty before snapshot, then reset counter values
        read_all("R1");
        snap_read("R1");

        // R2: free running seconds after reset
        idle(3 * PERIOD);
        snap_read("R2");

        // R3: minute and hour wraps
        set_time(8'h59, 8'h59, 8'h10, 8'h03, 8'h15, 8'h06, 8'h42);
        idle(PERIOD);
        snap_read("R3");

        // R4, R5, R7: end of century, day of week 7 -> 1
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        idle(PERIOD);
        snap_read("R7");
        read_all("R4");

        // R6: leap February, common February, year 00
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        idle(PERIOD);
        snap_read("R6");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        idle(PERIOD);
        snap_read("R6");
        set_time(8'h59, 8'h59, 8'hA3, 8'h05, 8'h29, 8'h02, 8'h00);
        idle(PERIOD);
        snap_read("R6");

        // R5: thirty-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h17);
        idle(PERIOD);
        snap_read("R5");

        // R10: shadow unchanged across later seconds
        snap_read("R10");
        idle(2 * PERIOD + 5);
        read_all("R10");

        // R8: address 7 write ignored, masks applied
        step(1'b1, 3'd7, 8'hFF, 1'b0);
        step(1'b1, 3'd3, 8'hFD, 1'b0);
        snap_read("R8");

        // R9: seconds write mid-period restarts the phase
        idle(7);
        step(1'b1, 3'd0, 8'h30, 1'b0);
        idle(PERIOD - 2);
        snap_read("R9");
        snap_read("R9");

        // Random valid times with random run lengths
        for (int it = 0; it < 10; it++) begin
            int mo, y, dt;
            mo = int'($urandom_range(12, 1));
            y  = int'($urandom_range(99, 0));
            dt = int'($urandom_range(days_of(mo, y), 1));
            set_time(i2b(int'($urandom_range(59, 50))), i2b(int'($urandom_range(59, 0))),
                     i2b(int'($urandom_range(23, 0))) | {1'($urandom_range(1, 0)), 7'b0},
                     i2b(int'($urandom_range(7, 1))), i2b(dt), i2b(mo), i2b(y));
            idle(int'($urandom_range(40 * PERIOD, 0)));
            snap_read("R3");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule